// File: doc/BRIEF.md
# Multi-Line Bit Register Bank

This block keeps a one-bit line value for each of 128 serial lines, together with a read-pending and a write-pending flag per line. A 7-bit line register picks the line that an operation touches. The host steers the block with a command strobe and a 4-bit command code. Along with each command it presents a 12-bit data word, which serves as the accumulator on transmit. The data output carries the command's result.

A transmit clears a link bit and rotates the 13-bit value {link, accumulator} right by one. The accumulator's least significant bit ends up in the link, and the link value is written into the selected line's bit. The rotated accumulator comes back on the data output in the same cycle. A receive command reports the selected line's bit and its two flags. The transmit and receive commands each have a variant that first steps the line register and then acts on the new line. Baud timing and character assembly belong to the surrounding logic.

Top module: `multi_line_bank`

## Requirements
- R1: Command 0 (step) increments the line register by one, modulo 128, so 127 becomes 0.
- R2: Command 1 (zero) clears the line register. Command 2 (report) puts the line register, zero-extended, on the data output and changes no state.
- R3: Command 3 (merge) ORs data input bits 6:0 into the line register. Command 4 (load) clears the register and then ORs those bits in. Both commands output 0.
- R4: After reset every line bit is 1, every pending flag is 0 and the line register is 0.
- R5: Command 5 (send) outputs {0, dataIn[11:1]} in the same cycle as its strobe.
- R6: A send writes dataIn[0] into the selected line's bit and sets that line's read-pending and write-pending flags. No other line changes.
- R7: Command 7 (sample) outputs the selected line's bit in bit 0, its read-pending flag in bit 1 and its write-pending flag in bit 2, with zeros above. It changes no state.
- R8: Command 6 (step-send) and command 8 (step-sample) increment the line register modulo 128 and then act, within the same cycle, on the line the incremented value selects.
- R9: While the strobe is low, or for command codes 9 to 15, no state changes and the data output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| strobe | input | 1 | Command valid for this cycle |
| cmd | input | 4 | Command code |
| dataIn | input | 12 | Accumulator or line register operand |
| dataOut | output | 12 | Command result, combinational |

## Verification
In the step-send and step-sample commands, the line register increment and the line access fall in the same cycle. The access must reach the line after the incremented one, and it must do so in the cycle of the increment itself. The bench provokes this at the wrap from 127 to 0 and also under long random command streams. A reference model that increments first and acts second judges the data output on every cycle. Later sample commands then read back which line's bit and flags were actually written.

// File: rtl/line_bank_pkg.sv
package line_bank_pkg;
  typedef enum logic [3:0] {
    CMD_STEP      = 4'd0,
    CMD_ZERO      = 4'd1,
    CMD_REPORT    = 4'd2,
    CMD_MERGE     = 4'd3,
    CMD_LOAD      = 4'd4,
    CMD_SEND      = 4'd5,
    CMD_STEP_SEND = 4'd6,
    CMD_SAMPLE    = 4'd7,
    CMD_STEP_SAMP = 4'd8
  } cmd_e;

  typedef struct packed {
    logic incLine;
    logic clrLine;
    logic orLine;
    logic readLine;
    logic send;
    logic readBit;
  } bank_ctl_t;
endpackage

// File: rtl/line_bank_ctrl.sv
module line_bank_ctrl
  import line_bank_pkg::*;
(
  input  logic      strobe,
  input  logic [3:0] cmd,
  output bank_ctl_t ctl
);
  always_comb begin
    ctl = '0;
    if (strobe) begin
      unique case (cmd)
        CMD_STEP:      ctl.incLine = 1'b1;
        CMD_ZERO:      ctl.clrLine = 1'b1;
        CMD_REPORT:    ctl.readLine = 1'b1;
        CMD_MERGE:     ctl.orLine = 1'b1;
        CMD_LOAD:      begin ctl.clrLine = 1'b1; ctl.orLine = 1'b1; end
        CMD_SEND:      ctl.send = 1'b1;
        CMD_STEP_SEND: begin ctl.incLine = 1'b1; ctl.send = 1'b1; end
        CMD_SAMPLE:    ctl.readBit = 1'b1;
        CMD_STEP_SAMP: begin ctl.incLine = 1'b1; ctl.readBit = 1'b1; end
        default:       ctl = '0;
      endcase
    end
  end
endmodule

// File: rtl/line_bank_dp.sv
module line_bank_dp
  import line_bank_pkg::*;
#(
  parameter int LINE_W = 7,
  parameter int ACC_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  bank_ctl_t         ctl,
  input  logic [ACC_W-1:0]  dataIn,
  output logic [ACC_W-1:0]  dataOut,
  output logic [LINE_W-1:0] lineReg
);
  localparam int NUM_LINES = 1 << LINE_W;

  logic [NUM_LINES-1:0] lineBits;
  logic [NUM_LINES-1:0] rdPend;
  logic [NUM_LINES-1:0] wrPend;
  logic [LINE_W-1:0]    stepped;
  logic [LINE_W-1:0]    selLine;
  logic [LINE_W-1:0]    nextLine;
  logic [ACC_W-1:0]     rotated;
  logic                 linkBit;

  assign stepped = lineReg + LINE_W'(1);
  assign selLine = ctl.incLine ? stepped : lineReg;

  // Link is cleared, then {link, acc} rotates right by one.
  always_comb begin
    {rotated, linkBit} = {1'b0, dataIn};
  end

  always_comb begin
    nextLine = selLine;
    if (ctl.clrLine) nextLine = '0;
    if (ctl.orLine)  nextLine = nextLine | dataIn[LINE_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineReg  <= '0;
      lineBits <= '1;
      rdPend   <= '0;
      wrPend   <= '0;
    end else begin
      lineReg <= nextLine;
      if (ctl.send) begin
        lineBits[selLine] <= linkBit;
        rdPend[selLine]   <= 1'b1;
        wrPend[selLine]   <= 1'b1;
      end
    end
  end

  always_comb begin
    dataOut = '0;
    if (ctl.readLine) dataOut[LINE_W-1:0] = lineReg;
    if (ctl.send)     dataOut = rotated;
    if (ctl.readBit)  dataOut[2:0] = {wrPend[selLine], rdPend[selLine], lineBits[selLine]};
  end
endmodule

// File: rtl/multi_line_bank.sv
module multi_line_bank
  import line_bank_pkg::*;
#(
  parameter int LINE_W = 7,
  parameter int ACC_W  = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             strobe,
  input  logic [3:0]       cmd,
  input  logic [ACC_W-1:0] dataIn,
  output logic [ACC_W-1:0] dataOut
);
  bank_ctl_t         ctl;
  logic [LINE_W-1:0] lineReg;

  line_bank_ctrl ctrl_i (
    .strobe (strobe),
    .cmd    (cmd),
    .ctl    (ctl)
  );

  line_bank_dp #(.LINE_W(LINE_W), .ACC_W(ACC_W)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .dataIn  (dataIn),
    .dataOut (dataOut),
    .lineReg (lineReg)
  );
endmodule

// File: rtl/line_bank_chk.sv
module line_bank_chk
  import line_bank_pkg::*;
#(
  parameter int LINE_W = 7,
  parameter int ACC_W  = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              strobe,
  input logic [3:0]        cmd,
  input logic [ACC_W-1:0]  dataIn,
  input logic [ACC_W-1:0]  dataOut,
  input logic [LINE_W-1:0] lineReg
);
  p_step_wrap_r1: assert property (@(posedge clk) disable iff (!rstN)
    (strobe && cmd == CMD_STEP) |=> (lineReg == $past(lineReg) + LINE_W'(1)));

  p_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe && cmd == CMD_ZERO) |=> (lineReg == '0));

  p_merge_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe && (cmd == CMD_MERGE || cmd == CMD_LOAD)) |-> (dataOut == '0));

  p_load_value_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe && cmd == CMD_LOAD) |=> (lineReg == $past(dataIn[LINE_W-1:0])));

  p_send_rotate_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe && cmd == CMD_SEND) |-> (dataOut[ACC_W-1] == 1'b0 && dataOut[ACC_W-2:0] == dataIn[ACC_W-1:1]));

  p_step_send_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe && cmd == CMD_STEP_SEND) |=> (lineReg == $past(lineReg) + LINE_W'(1)));

  p_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe) |=> $stable(lineReg));

  p_idle_out_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe || cmd > 4'd8) |-> (dataOut == '0));
endmodule

bind multi_line_bank line_bank_chk #(.LINE_W(LINE_W), .ACC_W(ACC_W)) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .strobe  (strobe),
  .cmd     (cmd),
  .dataIn  (dataIn),
  .dataOut (dataOut),
  .lineReg (lineReg)
);

// File: tb/multi_line_bank_tb.sv
`timescale 1ns/100ps
module multi_line_bank_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        strobe = 1'b0;
  logic [3:0]  cmd = 4'd0;
  logic [11:0] dataIn = 12'd0;
  logic [11:0] dataOut;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference state
  int mLine = 0;
  bit mBit[128];
  bit mRd[128];
  bit mWr[128];

  multi_line_bank dut_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cmd(cmd),
    .dataIn(dataIn), .dataOut(dataOut)
  );

  always #2.5 clk = ~clk;

  function automatic string reqTag(input bit s, input int c);
    if (!s || c > 8) return "R9";
    case (c)
      0: return "R1";
      1, 2: return "R2";
      3, 4: return "R3";
      5: return "R5";
      6, 8: return "R8";
      default: return "R7";
    endcase
  endfunction

  task automatic step(input bit s, input int c, input int d);
    int sel;
    int exp;
    string tag;
    @(negedge clk);
    strobe = s;
    cmd = 4'(c);
    dataIn = 12'(d);
    #1;
    exp = 0;
    sel = mLine;
    if (s && (c == 0 || c == 6 || c == 8)) sel = (mLine + 1) % 128;
    if (s) begin
      case (c)
        2: exp = mLine;
        5, 6: exp = (d & 12'hFFF) >> 1;
        7, 8: exp = (mWr[sel] << 2) | (mRd[sel] << 1) | mBit[sel];
        default: exp = 0;
      endcase
    end
    tag = reqTag(s, c);
    checks++;
    if (dataOut !== 12'(exp)) begin
      errors++;
      $display("FAIL %s cmd=%0d strobe=%0d: dataOut=%0h expected=%0h", tag, c, s, dataOut, exp);
    end
    if (s) begin
      case (c)
        0: mLine = sel;
        1: mLine = 0;
        3: mLine = mLine | (d & 127);
        4: mLine = d & 127;
        5, 6: begin
          mLine = sel;
          mBit[sel] = d[0];
          mRd[sel] = 1;
          mWr[sel] = 1;
        end
        8: mLine = sel;
        default: ;
      endcase
    end
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 128; i++) begin mBit[i] = 1; mRd[i] = 0; mWr[i] = 0; end
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    // R4: reset state, line register 0, every line idle-high with no flags
    step(1, 2, 0);
    for (int i = 0; i < 128; i++) begin
      step(1, 7, 0);   // R4 sample line i
      step(1, 0, 0);
    end
    step(1, 2, 0);     // R1 wrapped back to 0 after 128 steps
    // R3 merge and load
    step(1, 3, 12'hF05);
    step(1, 3, 12'h012);
    step(1, 2, 0);
    step(1, 4, 12'hA7F);
    step(1, 2, 0);
    // R5/R6 send at line 127, then R8 step-send wraps to line 0
    step(1, 5, 12'hABE);
    step(1, 7, 0);
    step(1, 6, 12'h555);
    step(1, 2, 0);
    step(1, 7, 0);
    step(1, 1, 0);     // R2 zero
    step(1, 2, 0);
    step(1, 8, 0);     // R8 step-sample at line 1
    // R9 idle and unused codes
    step(0, 5, 12'hFFF);
    step(1, 12, 12'hFFF);
    step(1, 15, 12'h07F);
    step(1, 2, 0);
    step(1, 7, 0);
    // random stream
    for (int n = 0; n < 4000; n++) begin
      int c;
      int s;
      c = $urandom_range(0, 15);
      s = ($urandom_range(0, 7) != 0);
      step(s[0], c, $urandom_range(0, 4095));
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule